// File: doc/BRIEF.md
# Ratiometric Sampling Converter Controller

This block is the digital side of a multi-channel sampling converter with a 32-bit register interface. Each channel's sample is presented as an unsigned 32-bit value on a wide parallel port. Two 32-bit reference values also arrive as inputs, one external and one internal (2,000,000 in normal use). Software writes a control word that selects a channel, a reference, a clock divider and interrupt behaviour, and then sets the start bit.

The block times the conversion with a prescaled counter. It computes the code `min(1023, floor(sample * 1024 / reference))` with a ten-step restoring divider that runs while the counter is still counting. When the counter expires, it loads the code into a read-only data word and clears the start bit. If interrupts are enabled, it also sets a sticky flag and raises a level interrupt.

The control word also carries a write-one-to-clear interrupt flag and a self-clearing soft-reset request. Every bus request is answered with a ready pulse one cycle later.

Top module: `sampconv_ctrl`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0x000C0001, the data word (offset 0x4) reads 0, and `irq` is low.
- R2: `respReady` is high in the cycle after every request. A read of 0x0 returns the control word and a read of 0x4 returns the data word. A read of any other address, including unaligned ones such as 0x2, returns 0. Writes to 0x4 or to any other address except 0x0 change nothing.
- R3: A conversion starts only on a control write in which enable (bit 17) and start (bit 13) are both 1 while bit 13 currently reads 0. Bit 13 reads 1 while the conversion runs. Writing bit 13 as 1 again during a conversion does not restart its timing.
- R4: The conversion completes 40 × (D + 1) clock cycles after the edge that accepted the starting write, where D is the divider field in bits 8:1 of that write.
- R5: On completion the data word holds `min(1023, floor(S × 1024 / V))`. S is the sample of the channel chosen by bits 27:24. V is the internal reference when bit 19 is 1 and the external reference when bit 19 is 0. S and V are sampled at the start, and V = 0 gives 1023.
- R6: On completion bit 13 clears. If interrupt enable (bit 21) is 1, the flag (bit 18) is set and `irq` rises. If bit 21 is 0, neither changes.
- R7: A control write with bit 18 = 1 clears the flag and drives `irq` low. A control write with bit 18 = 0 leaves the flag and `irq` as they were.
- R8: A control write with bit 13 = 0 aborts a running conversion: no data update, no flag and no interrupt follow.
- R9: A control write with bit 16 = 1 restores the control word to 0x000C0001 and the data word to 0, drives `irq` low, and aborts any conversion.
- R10: If the channel field is 8 or more, the completion leaves the data word, bit 13, the flag and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Bus request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address of the access |
| reqWdata | input | 32 | Write data |
| respReady | output | 1 | Response strobe, one cycle after a request |
| respRdata | output | 32 | Read data, valid with respReady |
| chanBus | input | 256 | Eight 32-bit channel samples, channel i at bits 32i+31:32i |
| extRef | input | 32 | External reference value |
| intRef | input | 32 | Internal reference value |
| irq | output | 1 | Level interrupt |

## Verification
Register reads take effect at the request edge, and read data and ready appear after that edge. The bench therefore drives each request at a falling edge and samples one falling edge later. The completion lands exactly 40 × (D + 1) rising edges after the accepting edge. The bench records a free-running edge count at the falling edge after the start write, then steps falling edge by falling edge until `irq` rises, and compares the difference against that figure. For completions without an interrupt, and for aborted or invalid-channel conversions, the bench waits past the full conversion time plus a margin before it reads the registers and checks `irq`.

// File: rtl/sampconv_pkg.sv
package sampconv_pkg;

  // control word bit positions (decoded by software, so fixed)
  localparam int B_CONV  = 13;
  localparam int B_SRST  = 16;
  localparam int B_EN    = 17;
  localparam int B_FLAG  = 18;
  localparam int B_REF   = 19;
  localparam int B_IEN   = 21;
  localparam int CH_LSB  = 24;
  localparam int CH_W    = 4;
  localparam int DIV_LSB = 1;

  localparam logic [31:0] CON_RESET = 32'h000C_0001;
  localparam int CON_OFF  = 0;
  localparam int DATA_OFF = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // capture operands and start the divider
    logic commit;   // conversion time elapsed, load result
    logic clear;    // soft reset of the datapath
  } dpCmd_t;

endpackage

// File: rtl/sampconv_dp.sv
module sampconv_dp
  import sampconv_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int RES_BITS = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dpCmd_t                   cmd,
  input  logic [CH_W-1:0]          selChan,
  input  logic                     useInt,
  input  logic [NUM_CH*DATA_W-1:0] chanBus,
  input  logic [DATA_W-1:0]        extRef,
  input  logic [DATA_W-1:0]        intRef,
  output logic [31:0]              dataReg,
  output logic                     chanOk
);

  localparam int STEP_W = $clog2(RES_BITS + 1);
  localparam logic [RES_BITS-1:0] MAX_CODE = '1;

  logic [DATA_W-1:0] chanArr [NUM_CH];
  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign chanArr[g] = chanBus[g*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] chanSel;
  always_comb begin
    chanSel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(selChan) == i) chanSel = chanArr[i];
    end
  end

  logic              chanValid;
  logic [DATA_W-1:0] refVal;
  assign chanValid = int'(selChan) < NUM_CH;
  assign refVal    = useInt ? intRef : extRef;

  logic [DATA_W:0]       remReg;
  logic [DATA_W-1:0]     divisor;
  logic [RES_BITS-1:0]   quot;
  logic                  satFlag;
  logic [STEP_W-1:0]     stepCnt;
  logic [DATA_W:0]       shifted;
  logic                  geq;

  // remainder stays below the divisor, so its top bit is always free
  assign shifted = {remReg[DATA_W-1:0], 1'b0};
  assign geq     = shifted >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remReg  <= '0;
      divisor <= '0;
      quot    <= '0;
      satFlag <= 1'b0;
      stepCnt <= '0;
      chanOk  <= 1'b0;
      dataReg <= '0;
    end else if (cmd.clear) begin
      stepCnt <= '0;
      chanOk  <= 1'b0;
      dataReg <= '0;
    end else begin
      if (cmd.launch) begin
        remReg  <= {1'b0, chanSel};
        divisor <= refVal;
        quot    <= '0;
        satFlag <= chanSel >= refVal;   // covers a zero reference too
        stepCnt <= STEP_W'(RES_BITS);
        chanOk  <= chanValid;
      end else if (stepCnt != '0) begin
        remReg  <= geq ? (shifted - {1'b0, divisor}) : shifted;
        quot    <= {quot[RES_BITS-2:0], geq};
        stepCnt <= stepCnt - 1'b1;
      end
      if (cmd.commit && chanOk) begin
        dataReg <= 32'(satFlag ? MAX_CODE : quot);
      end
    end
  end

  // R5: the quotient must be complete before the counter expires
  assert_div_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.commit |-> stepCnt == '0);

  // R5: the stored code never exceeds the saturation limit
  assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dataReg[31:RES_BITS] == '0);

endmodule

// File: rtl/sampconv_ctl.sv
module sampconv_ctl
  import sampconv_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DIV_W       = 8,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              respReady,
  output logic [31:0]       respRdata,
  input  logic [31:0]       dataReg,
  input  logic              chanOk,
  output dpCmd_t            cmd,
  output logic [CH_W-1:0]   selChan,
  output logic              useInt,
  output logic              irq
);

  localparam int CNT_W = $clog2(2 * CONV_CYCLES * (2 ** DIV_W));

  logic [31:0]      conReg;
  logic             irqLvl;
  logic             running;
  logic [CNT_W-1:0] cnt;

  logic conHit, dataHit, conWr, softRst, startConv, cancelConv, finish;
  logic [31:0]      wrVal;
  logic [DIV_W-1:0] divField;
  logic [CNT_W-1:0] cntLoad;

  assign conHit  = reqValid && (reqAddr == ADDR_W'(CON_OFF));
  assign dataHit = reqValid && (reqAddr == ADDR_W'(DATA_OFF));
  assign conWr   = conHit && reqWrite;

  assign softRst    = conWr && reqWdata[B_SRST];
  assign startConv  = conWr && !softRst && reqWdata[B_EN] && reqWdata[B_CONV]
                      && !conReg[B_CONV];
  assign cancelConv = conWr && !softRst && !reqWdata[B_CONV];
  // a completion that meets a control write waits one cycle
  assign finish     = running && (cnt == '0) && !conWr;

  assign divField = reqWdata[DIV_LSB +: DIV_W];
  assign cntLoad  = CNT_W'(2 * CONV_CYCLES) * (CNT_W'(divField) + CNT_W'(1))
                    - CNT_W'(1);

  always_comb begin
    wrVal         = reqWdata;
    wrVal[B_FLAG] = reqWdata[B_FLAG] ? 1'b0 : conReg[B_FLAG];
  end

  assign cmd.launch = startConv;
  assign cmd.commit = finish;
  assign cmd.clear  = softRst;
  assign selChan    = reqWdata[CH_LSB +: CH_W];
  assign useInt     = reqWdata[B_REF];
  assign irq        = irqLvl;

  // bus response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respReady <= 1'b0;
      respRdata <= '0;
    end else begin
      respReady <= reqValid;
      if (reqValid && !reqWrite) begin
        respRdata <= conHit ? conReg : (dataHit ? dataReg : 32'd0);
      end else begin
        respRdata <= '0;
      end
    end
  end

  // control word, interrupt, run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conReg  <= CON_RESET;
      irqLvl  <= 1'b0;
      running <= 1'b0;
    end else if (softRst) begin
      conReg  <= CON_RESET;
      irqLvl  <= 1'b0;
      running <= 1'b0;
    end else if (conWr) begin
      conReg <= wrVal;
      if (reqWdata[B_FLAG]) irqLvl <= 1'b0;
      if (startConv)       running <= 1'b1;
      else if (cancelConv) running <= 1'b0;
    end else if (finish) begin
      running <= 1'b0;
      if (chanOk) begin
        conReg[B_CONV] <= 1'b0;
        if (conReg[B_IEN]) begin
          conReg[B_FLAG] <= 1'b1;
          irqLvl         <= 1'b1;
        end
      end
    end
  end

  // conversion timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (softRst) begin
      cnt <= '0;
    end else if (startConv) begin
      cnt <= cntLoad;
    end else if (running && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respReady);

  assert_busy_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> conReg[B_CONV]);

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irqLvl |-> conReg[B_FLAG]);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conWr && reqWdata[B_FLAG]) |=> !irq);

  assert_softrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> (conReg == CON_RESET) && !running && !irq);

endmodule

// File: rtl/sampconv_ctrl.sv
module sampconv_ctrl
  import sampconv_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 32,
  parameter int RES_BITS    = 10,
  parameter int ADDR_W      = 12,
  parameter int DIV_W       = 8,
  parameter int CONV_CYCLES = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [31:0]              reqWdata,
  output logic                     respReady,
  output logic [31:0]              respRdata,
  input  logic [NUM_CH*DATA_W-1:0] chanBus,
  input  logic [DATA_W-1:0]        extRef,
  input  logic [DATA_W-1:0]        intRef,
  output logic                     irq
);

  dpCmd_t          cmd;
  logic [CH_W-1:0] selChan;
  logic            useInt;
  logic [31:0]     dataReg;
  logic            chanOk;

  sampconv_ctl #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CONV_CYCLES(CONV_CYCLES)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .respReady(respReady), .respRdata(respRdata),
    .dataReg(dataReg), .chanOk(chanOk), .cmd(cmd),
    .selChan(selChan), .useInt(useInt), .irq(irq)
  );

  sampconv_dp #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .RES_BITS(RES_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .selChan(selChan), .useInt(useInt), .chanBus(chanBus),
    .extRef(extRef), .intRef(intRef),
    .dataReg(dataReg), .chanOk(chanOk)
  );

endmodule

// File: tb/sampconv_ctrl_bench.sv
module sampconv_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam logic [31:0] F_CONV = 32'h1 << 13;
  localparam logic [31:0] F_SRST = 32'h1 << 16;
  localparam logic [31:0] F_EN   = 32'h1 << 17;
  localparam logic [31:0] F_FLAG = 32'h1 << 18;
  localparam logic [31:0] F_REF  = 32'h1 << 19;
  localparam logic [31:0] F_IEN  = 32'h1 << 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic respReady;
  logic [31:0] respRdata;
  logic [NCH*32-1:0] chanBus = '0;
  logic [31:0] extRef = 32'd1_500_000;
  logic [31:0] intRef = 32'd2_000_000;
  logic irq;

  int total = 0, bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sampconv_ctrl u_sampconv_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .respReady(respReady),
    .respRdata(respRdata), .chanBus(chanBus), .extRef(extRef),
    .intRef(intRef), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    d = respRdata; rdy = respReady;
    reqValid = 1'b0;
  endtask

  function automatic logic [31:0] expCode(input longint unsigned s, input longint unsigned v);
    longint unsigned q;
    if (v == 0) return 32'd1023;
    q = (s * 1024) / v;
    return (q > 1023) ? 32'd1023 : 32'(q);
  endfunction

  function automatic logic [31:0] ctlWord(input int ch, input int rs, input int dv, input int ien);
    return (32'(ch) << 24) | (ien != 0 ? F_IEN : 32'h0) | (rs != 0 ? F_REF : 32'h0)
           | F_EN | F_CONV | (32'(dv) << 1);
  endfunction

  task automatic waitIrq(input int lim, output int lat, input int t0);
    int n = 0;
    while (!irq && n < lim) begin @(negedge clk); n++; end
    lat = cyc - t0;
  endtask

  // full conversion with checks on result, timing and status
  task automatic convRun(input int ch, input int rs, input int dv, input int ien,
                         input logic [31:0] s, input string tag);
    logic [31:0] rd; logic rdy; int t0, lat, tot;
    tot = 40 * (dv + 1);
    chanBus[ch*32 +: 32] = s;
    busWrite(12'h0, F_FLAG | F_EN);
    busWrite(12'h0, ctlWord(ch, rs, dv, ien));
    t0 = cyc;
    if (ien != 0) begin
      waitIrq(tot + 50, lat, t0);
      check({tag, " R4 latency"}, 32'(lat), 32'(tot));
    end else begin
      repeat (tot + 3) @(negedge clk);
      check({tag, " R6 irq stays low"}, {31'b0, irq}, 32'h0);
    end
    busRead(12'h4, rd, rdy);
    check({tag, " R5 code"}, rd, expCode(s, (rs != 0) ? intRef : extRef));
    busRead(12'h0, rd, rdy);
    check({tag, " R6 busy cleared"}, {31'b0, rd[13]}, 32'h0);
    check({tag, " R6 flag"}, {31'b0, rd[18]}, 32'(ien != 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=finished", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, keep;
    logic rdy;
    int t0, lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    busRead(12'h0, rd, rdy);
    check("R1 control", rd, 32'h000C0001);
    check("R2 ready on read", {31'b0, rdy}, 32'h1);
    busRead(12'h4, rd, rdy);
    check("R1 data", rd, 32'h0);

    // R4 timing for several dividers
    for (int dv = 0; dv < 6; dv++) begin
      convRun(dv % NCH, 1, dv, 1, 32'd700_000 + 32'(dv), "timing");
    end

    // R5 ratio sweep on the external reference
    extRef = 32'd3_000_017;
    for (int k = 0; k <= 17; k++) begin
      convRun(k % NCH, 0, 0, 1, 32'((longint'(extRef) * k) / 16), "ratio");
    end

    // R5 every channel with both references
    extRef = 32'd1_500_000;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int rs = 0; rs < 2; rs++) begin
        convRun(ch, rs, 0, 1, 32'((ch + 1) * 230_000 + ch), "channel");
      end
    end

    // R5 boundaries: reference minus one, equal, zero reference, full scale
    extRef = 32'hFFFF_FFFF;
    convRun(3, 0, 0, 1, 32'hFFFF_FFFE, "edge near");
    convRun(3, 0, 0, 1, 32'hFFFF_FFFF, "edge equal");
    extRef = 32'd0;
    convRun(4, 0, 0, 1, 32'd5, "edge zero ref");
    extRef = 32'd1000;
    convRun(5, 0, 0, 1, 32'd999, "edge ref-1");
    convRun(6, 0, 0, 1, 32'd0, "edge zero in");

    // R6 interrupt disabled
    convRun(2, 1, 1, 0, 32'd1_000_000, "no-ien");

    // R7 write 0 keeps flag, write 1 clears
    convRun(1, 1, 0, 1, 32'd400_000, "w1c prep");
    busWrite(12'h0, F_EN);
    busRead(12'h0, rd, rdy);
    check("R7 flag kept", {31'b0, rd[18]}, 32'h1);
    check("R7 irq kept", {31'b0, irq}, 32'h1);
    busWrite(12'h0, F_FLAG);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    busRead(12'h0, rd, rdy);
    check("R7 flag cleared", {31'b0, rd[18]}, 32'h0);

    // R3 rewriting start does not restart
    busWrite(12'h0, ctlWord(0, 1, 1, 1));
    t0 = cyc;
    busRead(12'h0, rd, rdy);
    check("R3 busy reads 1", {31'b0, rd[13]}, 32'h1);
    repeat (20) @(negedge clk);
    busWrite(12'h0, ctlWord(0, 1, 1, 1));
    waitIrq(200, lat, t0);
    check("R3 no restart latency", 32'(lat), 32'd80);

    // R3 start needs enable
    busWrite(12'h0, F_FLAG);
    busWrite(12'h0, ctlWord(0, 1, 0, 1) & ~F_EN);
    repeat (60) @(negedge clk);
    check("R3 no start without enable", {31'b0, irq}, 32'h0);
    busWrite(12'h0, F_EN);

    // R8 abort
    convRun(7, 1, 0, 1, 32'd1_234_567, "abort prep");
    busRead(12'h4, keep, rdy);
    chanBus[7*32 +: 32] = 32'd10;
    busWrite(12'h0, F_FLAG | F_EN);
    busWrite(12'h0, ctlWord(7, 1, 0, 1));
    repeat (10) @(negedge clk);
    busWrite(12'h0, F_EN | F_IEN);
    repeat (60) @(negedge clk);
    check("R8 no irq", {31'b0, irq}, 32'h0);
    busRead(12'h4, rd, rdy);
    check("R8 data unchanged", rd, keep);
    busRead(12'h0, rd, rdy);
    check("R8 no flag", {31'b0, rd[18]}, 32'h0);

    // R10 invalid channel
    busWrite(12'h0, ctlWord(9, 1, 0, 1));
    repeat (60) @(negedge clk);
    check("R10 no irq", {31'b0, irq}, 32'h0);
    busRead(12'h4, rd, rdy);
    check("R10 data unchanged", rd, keep);
    busRead(12'h0, rd, rdy);
    check("R10 busy stays", {31'b0, rd[13]}, 32'h1);
    check("R10 no flag", {31'b0, rd[18]}, 32'h0);
    busWrite(12'h0, F_EN);

    // R2 ignored writes and unmapped reads
    busWrite(12'h4, 32'hFFFF_FFFF);
    busRead(12'h4, rd, rdy);
    check("R2 data write ignored", rd, keep);
    busWrite(12'h8, 32'hFFFF_FFFF);
    busRead(12'h0, rd, rdy);
    check("R2 stray write ignored", rd, F_EN);
    busRead(12'h8, rd, rdy);
    check("R2 unmapped read", rd, 32'h0);
    check("R2 ready", {31'b0, rdy}, 32'h1);
    busRead(12'h2, rd, rdy);
    check("R2 unaligned read", rd, 32'h0);

    // R9 soft reset during a conversion with a pending flag
    convRun(0, 1, 0, 1, 32'd900_000, "srst prep");
    busWrite(12'h0, ctlWord(0, 1, 0, 1) | F_FLAG);
    repeat (5) @(negedge clk);
    busWrite(12'h0, F_SRST);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    busRead(12'h0, rd, rdy);
    check("R9 control reset", rd, 32'h000C0001);
    busRead(12'h4, rd, rdy);
    check("R9 data reset", rd, 32'h0);
    repeat (60) @(negedge clk);
    check("R9 aborted, no irq", {31'b0, irq}, 32'h0);
    busRead(12'h4, rd, rdy);
    check("R9 data still 0", rd, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule